// File: doc/BRIEF.md
# Two-Operand Register ALU

This block is the purely combinational integer datapath of a register-to-register instruction set in which one register is both the first source and the destination. A 4-bit operation code selects what is done to the two 32-bit operands: the destination's current value (the first operand) and the second source value. The block returns one 32-bit value for the register file to write back into the destination register.

The operations are wrapping addition and subtraction, three variable shifts, three bitwise functions, a signed and an unsigned less-than test, and a move of the second operand. Codes that no operation uses give a zero result and raise an invalid-operation flag. The block does not evaluate branches, does not access memory and does not store any register state. It has no clock and no reset. A result is valid once its inputs have settled.

Top module: `rr_alu`

## Requirements
- R1: Code 0x0 gives the first operand plus the second, truncated to 32 bits; no overflow indication exists.
- R2: Code 0x1 gives the first operand minus the second, truncated to 32 bits.
- R3: Code 0x2 shifts the first operand left, filling the vacated low bits with zeros.
- R4: For every shift code, the distance is the value of the second operand's bits 4..0; its bits 31..5 have no effect on the result.
- R5: Code 0x3 shifts the first operand right, and every vacated upper bit takes the first operand's original bit 31.
- R6: Code 0x4 shifts the first operand right, filling the vacated upper bits with zeros.
- R7: Code 0x5 gives the bitwise AND of the operands, code 0x6 gives the bitwise OR, and code 0x7 gives the bitwise complement of the OR.
- R8: Code 0x8 gives 32'h1 when the first operand is less than the second as signed two's-complement numbers, and 32'h0 otherwise.
- R9: Code 0x9 gives 32'h1 when the first operand is less than the second as unsigned numbers, and 32'h0 otherwise.
- R10: Code 0xA gives the second operand unchanged.
- R11: Codes 0xB through 0xF give a zero result with `bad_op_o` at 1; codes 0x0 through 0xA hold `bad_op_o` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| dst_val_i | input | 32 | First operand: the current value of the destination register |
| src_val_i | input | 32 | Second operand: the value of the second source register |
| result_o | output | 32 | Value to write back into the destination register |
| bad_op_o | output | 1 | High when the operation code is unassigned |

## Verification
The bench targets the following corner cases:

- **Sign boundary.** Operands at 0x80000000 and 0x7FFFFFFF are used where signed and unsigned ordering disagree. A compare that reuses the wrong borrow or sign bit returns the inverted answer there.
- **Shift distance.** The bench sweeps distances from 0 to 31 and pairs them with second operands whose upper bits are set, including 32 itself. A shifter that decodes more than five bits returns zero or a wrong fill instead of the expected shift.
- **Arithmetic shift.** Negative values are shifted arithmetically to catch a fill taken from a constant rather than from bit 31.
- **Carry and borrow.** Carries and borrows are forced to run across all 32 bits, so that a missing wrap shows up.
- **Unassigned codes.** All five unassigned codes are run with non-zero operands. A decoder that falls through to another unit leaks that unit's value onto the result.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

    localparam int XLEN      = 32;
    localparam int OP_W      = 4;
    localparam int LAST_OP   = 10;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_SHL  = 4'h2,
        OP_SHRA = 4'h3,
        OP_SHRL = 4'h4,
        OP_AND  = 4'h5,
        OP_OR   = 4'h6,
        OP_NOR  = 4'h7,
        OP_LTS  = 4'h8,
        OP_LTU  = 4'h9,
        OP_MOVE = 4'hA
    } alu_op_e;

    typedef enum logic [2:0] {
        UNIT_ARITH,
        UNIT_SHIFT,
        UNIT_BITS,
        UNIT_CMP,
        UNIT_MOVE,
        UNIT_NONE
    } unit_e;

    typedef enum logic [1:0] {
        SHK_LEFT,
        SHK_RIGHT_ARITH,
        SHK_RIGHT_LOGIC
    } shift_kind_e;

    typedef enum logic [1:0] {
        BWK_AND,
        BWK_OR,
        BWK_NOR
    } bits_kind_e;

    typedef struct packed {
        unit_e       unit;
        logic        subtract;
        shift_kind_e shk;
        bits_kind_e  bwk;
        logic        cmp_signed;
        logic        bad;
    } alu_ctrl_t;

    function automatic alu_ctrl_t decode_op(input logic [OP_W-1:0] op);
        alu_ctrl_t c;
        c.unit       = UNIT_NONE;
        c.subtract   = 1'b0;
        c.shk        = SHK_LEFT;
        c.bwk        = BWK_AND;
        c.cmp_signed = 1'b0;
        c.bad        = 1'b0;
        case (op)
            OP_ADD:  c.unit = UNIT_ARITH;
            OP_SUB:  begin c.unit = UNIT_ARITH; c.subtract = 1'b1; end
            OP_SHL:  begin c.unit = UNIT_SHIFT; c.shk = SHK_LEFT; end
            OP_SHRA: begin c.unit = UNIT_SHIFT; c.shk = SHK_RIGHT_ARITH; end
            OP_SHRL: begin c.unit = UNIT_SHIFT; c.shk = SHK_RIGHT_LOGIC; end
            OP_AND:  begin c.unit = UNIT_BITS;  c.bwk = BWK_AND; end
            OP_OR:   begin c.unit = UNIT_BITS;  c.bwk = BWK_OR; end
            OP_NOR:  begin c.unit = UNIT_BITS;  c.bwk = BWK_NOR; end
            OP_LTS:  begin c.unit = UNIT_CMP; c.subtract = 1'b1; c.cmp_signed = 1'b1; end
            OP_LTU:  begin c.unit = UNIT_CMP; c.subtract = 1'b1; end
            OP_MOVE: c.unit = UNIT_MOVE;
            default: c.bad = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rr_alu_addsub.sv
module rr_alu_addsub #(
    parameter int DATA_W = rr_alu_pkg::XLEN
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              lt_signed_o,
    output logic              lt_unsigned_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;
    logic              carry;

    always_comb begin
        b_eff = b_i ^ {DATA_W{sub_i}};
        wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
        sum_o = wide[DATA_W-1:0];
        carry = wide[DATA_W];
        // Unsigned borrow: a - b produced no carry out.
        lt_unsigned_o = sub_i & ~carry;
        // Signed: differing signs decide directly, else the difference sign.
        lt_signed_o = (a_i[MSB] != b_i[MSB]) ? a_i[MSB] : sum_o[MSB];
    end

    always_comb begin
        if (!sub_i) begin
            assert_add_inverse_R1: assert ((sum_o - b_i) == a_i)
                else $error("addsub: sum does not invert");
        end else begin
            assert_sub_inverse_R2: assert ((sum_o + b_i) == a_i)
                else $error("addsub: difference does not invert");
            if (a_i == b_i) begin
                assert_equal_not_less_R8: assert (!lt_signed_o && !lt_unsigned_o)
                    else $error("addsub: equal operands flagged less");
            end
        end
    end

endmodule

// File: rtl/rr_alu_shift.sv
module rr_alu_shift
    import rr_alu_pkg::*;
#(
    parameter int DATA_W  = rr_alu_pkg::XLEN,
    parameter int SHAMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0]  opnd_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  shift_kind_e        kind_i,
    output logic [DATA_W-1:0]  res_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] fwd;
    logic [DATA_W-1:0] core_out;
    logic [DATA_W-1:0] rev_in;
    logic [DATA_W-1:0] rev_out;
    logic [DATA_W-1:0] stg [SHAMT_W+1];
    logic              is_left;
    logic              fill;

    assign is_left = (kind_i == SHK_LEFT);
    assign fill    = (kind_i == SHK_RIGHT_ARITH) ? opnd_i[MSB] : 1'b0;

    // Left shifts reuse the right-shift core on a bit-reversed operand.
    for (genvar i = 0; i < DATA_W; i++) begin : g_rev
        assign rev_in[i]  = opnd_i[MSB-i];
        assign rev_out[i] = core_out[MSB-i];
    end

    assign fwd    = is_left ? rev_in : opnd_i;
    assign stg[0] = fwd;

    for (genvar s = 0; s < SHAMT_W; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][MSB:STEP]} : stg[s];
    end

    assign core_out = stg[SHAMT_W];
    assign res_o    = is_left ? rev_out : core_out;

    always_comb begin
        if (amt_i == '0) begin
            assert_zero_dist_R4: assert (res_o == opnd_i)
                else $error("shift: zero distance altered operand");
        end else begin
            if (kind_i == SHK_RIGHT_ARITH) begin
                assert_arith_fill_R5: assert (res_o[MSB] == opnd_i[MSB])
                    else $error("shift: arithmetic fill lost sign");
            end
            if (kind_i == SHK_RIGHT_LOGIC) begin
                assert_logic_fill_R6: assert (!res_o[MSB])
                    else $error("shift: logical fill not zero");
            end
            if (kind_i == SHK_LEFT) begin
                assert_left_fill_R3: assert (!res_o[0])
                    else $error("shift: left fill not zero");
            end
        end
    end

endmodule

// File: rtl/rr_alu_bitwise.sv
module rr_alu_bitwise
    import rr_alu_pkg::*;
#(
    parameter int DATA_W = rr_alu_pkg::XLEN
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  bits_kind_e        kind_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] any_one;

    always_comb begin
        any_one = a_i | b_i;
        unique case (kind_i)
            BWK_AND: res_o = a_i & b_i;
            BWK_OR:  res_o = any_one;
            BWK_NOR: res_o = ~any_one;
            default: res_o = '0;
        endcase
    end

    always_comb begin
        if (kind_i == BWK_AND) begin
            assert_and_within_R7: assert ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0)
                else $error("bitwise: AND set a bit absent from an operand");
        end
    end

endmodule

// File: rtl/rr_alu.sv
module rr_alu
    import rr_alu_pkg::*;
#(
    parameter int DATA_W = rr_alu_pkg::XLEN
) (
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] dst_val_i,
    input  logic [DATA_W-1:0] src_val_i,
    output logic [DATA_W-1:0] result_o,
    output logic              bad_op_o
);
    localparam int SHAMT_W = $clog2(DATA_W);

    alu_ctrl_t         ctrl;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] shift_res;
    logic [DATA_W-1:0] bits_res;
    logic              lt_s;
    logic              lt_u;
    logic              lt_pick;

    assign ctrl = decode_op(op_i);

    rr_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .a_i           (dst_val_i),
        .b_i           (src_val_i),
        .sub_i         (ctrl.subtract),
        .sum_o         (arith_res),
        .lt_signed_o   (lt_s),
        .lt_unsigned_o (lt_u)
    );

    rr_alu_shift #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W)) u_shift (
        .opnd_i (dst_val_i),
        .amt_i  (src_val_i[SHAMT_W-1:0]),
        .kind_i (ctrl.shk),
        .res_o  (shift_res)
    );

    rr_alu_bitwise #(.DATA_W(DATA_W)) u_bits (
        .a_i    (dst_val_i),
        .b_i    (src_val_i),
        .kind_i (ctrl.bwk),
        .res_o  (bits_res)
    );

    assign lt_pick = ctrl.cmp_signed ? lt_s : lt_u;

    always_comb begin
        unique case (ctrl.unit)
            UNIT_ARITH: result_o = arith_res;
            UNIT_SHIFT: result_o = shift_res;
            UNIT_BITS:  result_o = bits_res;
            UNIT_CMP:   result_o = {{(DATA_W-1){1'b0}}, lt_pick};
            UNIT_MOVE:  result_o = src_val_i;
            default:    result_o = '0;
        endcase
        bad_op_o = ctrl.bad;
    end

    always_comb begin
        if (bad_op_o) begin
            assert_bad_zero_R11: assert (result_o == '0)
                else $error("alu: unassigned code produced data");
        end
        if (op_i <= OP_W'(LAST_OP)) begin
            assert_valid_not_bad_R11: assert (!bad_op_o)
                else $error("alu: assigned code flagged bad");
        end
        if (op_i == OP_LTS || op_i == OP_LTU) begin
            assert_cmp_boolean_R9: assert (result_o[DATA_W-1:1] == '0)
                else $error("alu: compare result not boolean");
        end
        if (op_i == OP_MOVE) begin
            assert_move_pass_R10: assert (result_o == src_val_i)
                else $error("alu: move altered the source");
        end
    end

endmodule

// File: tb/rr_alu_tb_top.sv
`timescale 1ns/1ps
module rr_alu_tb_top;

    logic        clk = 1'b0;
    logic [3:0]  op_r = 4'h0;
    logic [31:0] a_r = 32'h0;
    logic [31:0] b_r = 32'h0;
    logic [31:0] res_w;
    logic        bad_w;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rr_alu dut_i (
        .op_i      (op_r),
        .dst_val_i (a_r),
        .src_val_i (b_r),
        .result_o  (res_w),
        .bad_op_o  (bad_w)
    );

    function automatic logic [31:0] model(input logic [3:0] op,
                                          input logic [31:0] a,
                                          input logic [31:0] b);
        int unsigned sh;
        sh = b % 32;
        case (op)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h2: return a << sh;
            4'h3: return 32'($signed(a) >>> sh);
            4'h4: return a >> sh;
            4'h5: return a & b;
            4'h6: return a | b;
            4'h7: return ~(a | b);
            4'h8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'h9: return (a < b) ? 32'd1 : 32'd0;
            4'hA: return b;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h0: return "R1";
            4'h1: return "R2";
            4'h2: return "R3";
            4'h3: return "R5";
            4'h4: return "R6";
            4'h5, 4'h6, 4'h7: return "R7";
            4'h8: return "R8";
            4'h9: return "R9";
            4'hA: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check_one(input logic [3:0] op, input logic [31:0] a,
                             input logic [31:0] b, input string tag);
        logic [31:0] exp_res;
        logic        exp_bad;
        @(posedge clk);
        op_r = op; a_r = a; b_r = b;
        @(negedge clk);
        exp_res = model(op, a, b);
        exp_bad = (op > 4'hA);
        n_checks++;
        if (res_w !== exp_res || bad_w !== exp_bad) begin
            n_fail++;
            $display("FAIL %s op=%h a=%h b=%h result=%h expected=%h bad=%b expected=%b",
                     tag, op, a, b, res_w, exp_res, bad_w, exp_bad);
        end
    endtask

    logic [31:0] corner [8];

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;
        corner[4] = 32'h7FFF_FFFF; corner[5] = 32'h0000_001F;
        corner[6] = 32'h0000_0020; corner[7] = 32'hA5A5_5A5A;

        // Idle state: add of zero operands, no invalid flag (R1)
        check_one(4'h0, 32'h0, 32'h0, "R1");

        // Every code against every corner pair
        for (int op = 0; op < 16; op++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    check_one(4'(op), corner[i], corner[j], tag_of(4'(op)));

        // R4: every distance with junk in the upper bits of the second operand
        for (int k = 0; k < 3; k++)
            for (int d = 0; d < 32; d++) begin
                logic [31:0] junk;
                junk = ($urandom() & 32'hFFFF_FFE0) | 32'h20 | 32'(d);
                check_one(4'(k + 2), 32'h9234_5671, junk, "R4");
                check_one(4'(k + 2), 32'h4C3B_2A19, junk, "R4");
            end

        // R11: unassigned codes with random non-zero operands
        for (int op = 11; op < 16; op++)
            for (int n = 0; n < 20; n++)
                check_one(4'(op), $urandom() | 32'h1, $urandom() | 32'h1, "R11");

        // Random sweep over all codes
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            check_one(op, $urandom(), $urandom(), tag_of(op));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule